// File: doc/BRIEF.md
# Serial Flash Status Write Protection

This block is the permission logic that guards the status register of a serial NOR flash slave. It receives already-decoded commands: a write-enable strobe, and a status-write strobe with the new status byte. It also receives the live level of the active-low write-protect pin and a busy flag from the program/erase engine. It stores the write-enable latch, a three-bit block-protect field and a status-write-disable bit. It decides whether each status write takes effect.

Hardware-protected mode holds when the stored disable bit is 1 and the pin is low. The mode can be reached in either order: set the bit and then pull the pin low, or set the bit while the pin is already low. It is left only by driving the pin high. While the mode holds, status writes are refused, so the block-protect field is frozen too. The field is driven out continuously for the program and erase logic. If the pin is always high, the mode never activates and only the block-protect field protects the array.

All outputs are registered, so every response appears one clock after the stimulus that causes it.

Top module: `flash_status_guard`

## Requirements
- R1: After a synchronous reset, wel_o, bp_o, srwd_o, hpm_o, wrsr_accept_o and wrsr_reject_o are all 0.
- R2: A write-enable strobe sets wel_o on the next clock, unless a status write is accepted in the same cycle.
- R3: A status write issued while the latch is clear is refused. wrsr_reject_o pulses for one cycle and bp_o, srwd_o and wel_o keep their values. wrsr_accept_o and wrsr_reject_o are never high together.
- R4: A status write issued with the latch set, busy low and no hardware protection is accepted. On the next clock, bp_o takes data bits [4:2], srwd_o takes data bit 7, wel_o clears and wrsr_accept_o pulses.
- R5: When srwd_o is 1 and wp_n_i is low, a status write is refused with no effect on bp_o or srwd_o, and wel_o stays set.
- R6: A status write issued while busy_i is high is refused with no effect on bp_o, srwd_o or wel_o.
- R7: hpm_o is the registered value of srwd_o AND NOT wp_n_i, one clock behind. It is reached both by pulling the pin low after the bit is set and by setting the bit while the pin is low.
- R8: hpm_o clears one clock after wp_n_i goes high. srwd_o stays 1 on exit, and a status write is then accepted again.
- R9: When a write-enable strobe and a status write share a cycle, the write is judged on the latch value from before that cycle. wel_o ends at 0 if the write is accepted and at 1 if it is refused.
- R10: Data bits other than 7 and [4:2] have no effect on the block's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Decoded write-enable strobe |
| wrsr_i | input | 1 | Decoded status-write strobe |
| wrsr_data_i | input | 8 | New status byte (bit 7 disable, bits 4:2 block protect) |
| wp_n_i | input | 1 | Write-protect pin level, low protects |
| busy_i | input | 1 | Program/erase/write cycle in progress |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 3 | Block-protect field |
| srwd_o | output | 1 | Status-write-disable bit |
| hpm_o | output | 1 | Hardware-protected mode |
| wrsr_accept_o | output | 1 | One-cycle pulse: status write taken |
| wrsr_reject_o | output | 1 | One-cycle pulse: status write refused |

## Verification
Two functions can fall in the same cycle: setting the write-enable latch and consuming it through a status write. The bench provokes this by raising wren_i and wrsr_i together, once with the latch clear and once with it set. It judges the outcome against a reference model that decides acceptance on the old latch value, so wel_o must end at 1 in the first case and at 0 in the second. A second overlap is between the pin and the disable bit: the bench moves wp_n_i and writes srwd in adjacent cycles and compares hpm_o and the accept/reject pulses cycle by cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int SR_W     = 8;
  localparam int BP_W     = 3;
  localparam int BP_LSB   = 2;
  localparam int SRWD_POS = 7;
endpackage

// File: rtl/fsg_wel.sv
module fsg_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk) begin
    if (rst)        wel_q <= 1'b0;
    else if (clr_i) wel_q <= 1'b0;
    else if (set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R2: a set with no competing clear lands next cycle
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> wel_q);
  // R4: consuming the latch clears it
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !wel_q);
  // R3: with no request the latch holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(wel_q));
endmodule

// File: rtl/fsg_gate.sv
module fsg_gate (
  input  logic clk,
  input  logic rst,
  input  logic wrsr_i,
  input  logic busy_i,
  input  logic wel_i,
  input  logic srwd_i,
  input  logic wp_n_i,
  output logic accept_o,
  output logic reject_o,
  output logic hpm_o
);
  logic locked;
  logic hpm_q;

  // protection from the stored bit and the live pin level
  assign locked   = srwd_i & ~wp_n_i;
  assign accept_o = wrsr_i & ~busy_i & wel_i & ~locked;
  assign reject_o = wrsr_i & ~accept_o;

  always_ff @(posedge clk) begin
    if (rst) hpm_q <= 1'b0;
    else     hpm_q <= locked;
  end

  assign hpm_o = hpm_q;

  // R6: busy always refuses
  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !accept_o);
  // R3: without the latch nothing is taken
  p_nowel_r3: assert property (@(posedge clk) disable iff (rst)
    !wel_i |-> !accept_o);
endmodule

// File: rtl/fsg_sreg.sv
module fsg_sreg #(
  parameter int SR_W     = fsg_pkg::SR_W,
  parameter int BP_W     = fsg_pkg::BP_W,
  parameter int BP_LSB   = fsg_pkg::BP_LSB,
  parameter int SRWD_POS = fsg_pkg::SRWD_POS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  output logic [BP_W-1:0] bp_o,
  output logic            srwd_o
);
  logic [BP_W-1:0] bp_q;
  logic            srwd_q;

  for (genvar i = 0; i < BP_W; i++) begin : g_bp
    always_ff @(posedge clk) begin
      if (rst)         bp_q[i] <= 1'b0;
      else if (load_i) bp_q[i] <= data_i[BP_LSB+i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         srwd_q <= 1'b0;
    else if (load_i) srwd_q <= data_i[SRWD_POS];
  end

  assign bp_o   = bp_q;
  assign srwd_o = srwd_q;

  // R5: fields change only through an accepted write
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(bp_q) && $stable(srwd_q)));
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int SR_W     = fsg_pkg::SR_W,
  parameter int BP_W     = fsg_pkg::BP_W,
  parameter int BP_LSB   = fsg_pkg::BP_LSB,
  parameter int SRWD_POS = fsg_pkg::SRWD_POS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wren_i,
  input  logic            wrsr_i,
  input  logic [SR_W-1:0] wrsr_data_i,
  input  logic            wp_n_i,
  input  logic            busy_i,
  output logic            wel_o,
  output logic [BP_W-1:0] bp_o,
  output logic            srwd_o,
  output logic            hpm_o,
  output logic            wrsr_accept_o,
  output logic            wrsr_reject_o
);
  logic wel;
  logic srwd;
  logic accept;
  logic reject;
  logic acc_q;
  logic rej_q;

  fsg_wel u_wel (
    .clk   (clk),
    .rst   (rst),
    .set_i (wren_i),
    .clr_i (accept),
    .wel_o (wel)
  );

  fsg_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .wrsr_i   (wrsr_i),
    .busy_i   (busy_i),
    .wel_i    (wel),
    .srwd_i   (srwd),
    .wp_n_i   (wp_n_i),
    .accept_o (accept),
    .reject_o (reject),
    .hpm_o    (hpm_o)
  );

  fsg_sreg #(
    .SR_W     (SR_W),
    .BP_W     (BP_W),
    .BP_LSB   (BP_LSB),
    .SRWD_POS (SRWD_POS)
  ) u_sreg (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .data_i (wrsr_data_i),
    .bp_o   (bp_o),
    .srwd_o (srwd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= accept;
      rej_q <= reject;
    end
  end

  assign wel_o         = wel;
  assign srwd_o        = srwd;
  assign wrsr_accept_o = acc_q;
  assign wrsr_reject_o = rej_q;

  // R3: the two result pulses are exclusive
  p_pulses_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wrsr_accept_o, wrsr_reject_o}));
  // R4: an accepted write leaves the latch clear
  p_acc_wel_r4: assert property (@(posedge clk) disable iff (rst)
    wrsr_accept_o |-> !wel_o);
  // R5: protected mode with the pin still low refuses a write
  p_hpm_block_r5: assert property (@(posedge clk) disable iff (rst)
    (hpm_o && !wp_n_i && wrsr_i) |=> !wrsr_accept_o);
  // R8: raising the pin releases protected mode
  p_exit_r8: assert property (@(posedge clk) disable iff (rst)
    wp_n_i |=> !hpm_o);
  // R6: a busy-time write is never taken
  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_i && wrsr_i) |=> (!wrsr_accept_o && wrsr_reject_o));
endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       wel;
    logic [2:0] bp;
    logic       srwd;
    logic       hpm;
    logic       acc;
    logic       rej;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wren_i = 1'b0;
  logic       wrsr_i = 1'b0;
  logic [7:0] wrsr_data_i = 8'h00;
  logic       wp_n_i = 1'b1;
  logic       busy_i = 1'b0;
  logic       wel_o;
  logic [2:0] bp_o;
  logic       srwd_o;
  logic       hpm_o;
  logic       wrsr_accept_o;
  logic       wrsr_reject_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  // reference model state
  logic       m_wel = 1'b0;
  logic [2:0] m_bp = 3'b000;
  logic       m_srwd = 1'b0;

  flash_status_guard u_dut (
    .clk           (clk),
    .rst           (rst),
    .wren_i        (wren_i),
    .wrsr_i        (wrsr_i),
    .wrsr_data_i   (wrsr_data_i),
    .wp_n_i        (wp_n_i),
    .busy_i        (busy_i),
    .wel_o         (wel_o),
    .bp_o          (bp_o),
    .srwd_o        (srwd_o),
    .hpm_o         (hpm_o),
    .wrsr_accept_o (wrsr_accept_o),
    .wrsr_reject_o (wrsr_reject_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic wr, input logic ws, input logic [7:0] d,
                      input logic wp, input logic bz, input string tag);
    exp_t e;
    logic acc;
    @(negedge clk);
    wren_i = wr; wrsr_i = ws; wrsr_data_i = d; wp_n_i = wp; busy_i = bz;
    acc = ws && !bz && m_wel && !(m_srwd && !wp);
    e.hpm = m_srwd && !wp;
    e.acc = acc;
    e.rej = ws && !acc;
    if (acc) begin
      m_bp   = d[4:2];
      m_srwd = d[7];
      m_wel  = 1'b0;
    end else if (wr) begin
      m_wel = 1'b1;
    end
    e.wel = m_wel; e.bp = m_bp; e.srwd = m_srwd; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({wel_o, bp_o, srwd_o, hpm_o, wrsr_accept_o, wrsr_reject_o} !==
          {e.wel, e.bp, e.srwd, e.hpm, e.acc, e.rej}) begin
        fails++;
        $display("FAIL %s: got wel=%b bp=%b srwd=%b hpm=%b acc=%b rej=%b, expected wel=%b bp=%b srwd=%b hpm=%b acc=%b rej=%b",
                 e.tag, wel_o, bp_o, srwd_o, hpm_o, wrsr_accept_o, wrsr_reject_o,
                 e.wel, e.bp, e.srwd, e.hpm, e.acc, e.rej);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if ({wel_o, bp_o, srwd_o, hpm_o, wrsr_accept_o, wrsr_reject_o} !== 8'b0) begin
      fails++;
      $display("FAIL R1: got %b, expected 00000000",
               {wel_o, bp_o, srwd_o, hpm_o, wrsr_accept_o, wrsr_reject_o});
    end
    step(0, 0, 8'h00, 1, 0, "R1");
    step(0, 1, 8'h9C, 1, 0, "R3");   // no latch: refused
    step(1, 0, 8'h00, 1, 0, "R2");
    step(0, 1, 8'h9C, 1, 1, "R6");   // busy: refused, latch kept
    step(0, 1, 8'h0C, 0, 0, "R4");   // pin low, bit clear: accepted, bp=011
    step(1, 0, 8'h00, 1, 0, "R2");
    step(0, 1, 8'hFF, 1, 0, "R10");  // bp=111, srwd=1, other bits ignored
    step(0, 0, 8'h00, 0, 0, "R7");   // pin low after bit set
    step(0, 0, 8'h00, 0, 0, "R7");
    step(1, 0, 8'h00, 0, 0, "R2");
    step(0, 1, 8'h00, 0, 0, "R5");   // locked: refused, latch kept
    step(0, 0, 8'h00, 0, 0, "R5");
    step(0, 0, 8'h00, 1, 0, "R8");   // exit
    step(0, 0, 8'h00, 1, 0, "R8");
    step(0, 1, 8'h80, 1, 0, "R8");   // accepted again, srwd stays 1
    step(1, 0, 8'h00, 1, 0, "R2");
    step(0, 1, 8'h00, 1, 0, "R4");   // clear srwd
    step(0, 0, 8'h00, 0, 0, "R7");   // pin low first, bit clear
    step(1, 0, 8'h00, 0, 0, "R2");
    step(0, 1, 8'h84, 0, 0, "R7");   // set bit while pin low
    step(0, 0, 8'h00, 0, 0, "R7");
    step(0, 0, 8'h00, 1, 0, "R8");
    step(1, 1, 8'h10, 1, 0, "R9");   // latch was clear: refused, latch ends set
    step(1, 1, 8'h10, 1, 0, "R9");   // latch set: accepted, latch ends clear
    step(0, 1, 8'h63, 1, 0, "R10");  // refused, no change
    step(0, 0, 8'h00, 1, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule